// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block is an SPI master with four active-low select outputs. A host loads it through a small write-only register port. A mode register picks plain or binary-coded select output and carries an end-of-burst flag. A data register holds one byte together with a 4-bit select field. Four profile registers each hold a hold-select bit and an idle delay. The block shifts the byte out in SPI mode 0, with the most significant bit first. It returns the received byte with a one-cycle valid pulse.

The sequencer controls the select lines between bytes. A line stays low through a burst when the next byte for the same target is written in time. It also stays low when the hold bit of the target's profile is set. The line is released after a byte that was written with the end-of-burst flag, and before the block switches to a different target. In coded mode the 4-bit field goes straight onto the pins, and an external decoder can then address up to 15 devices. A sticky fault flag watches line 0 for a low level that some other master drives.

Top module: `spim_cs_seq`

## Requirements
- R1: In plain mode (mode bit 0 = 0), at most one select line is low at any time, and the line driven is the lowest-numbered zero bit of the select field (data register bits 11:8 at address 1).
- R2: In coded mode (mode bit 0 = 1), the select field is driven unchanged onto `cs_n[3:0]` for the whole byte.
- R3: With no line held, `cs_n` reads 4'hF. It never reads 4'hF while a byte is shifting.
- R4: A byte whose field selects nothing is dropped. In coded mode that is field 4'hF, and in plain mode it is a field of all ones. After such a byte `tx_empty` returns to 1, no SCK edge occurs and `cs_n` is unchanged.
- R5: The profile used for a byte is register 4+k. In coded mode k is field/4 (integer division), so codes 0–3, 4–7, 8–11 and 12–14 share a profile. In plain mode k is the selected line. Profile bit 0 is the hold bit and bits 15:8 are the delay.
- R6: `tx_empty` goes to 1 in the cycle the byte is copied into the shifter. At that point the select line is already low and SCK has not yet risen.
- R7: If the next byte for the same target is written before the current byte ends, the line stays low between the two bytes even when the hold bit is 0.
- R8: With the hold bit set, the line stays low after the byte ends even when no new data arrives. It is released only when a byte for a different target is issued.
- R9: A byte written while mode bit 1 is set releases its line when it ends, whatever the hold bit says.
- R10: `mode_fault` is set when `cs0_sense_n` is low while the block drives line 0 high in plain mode. It cannot be set while the block holds line 0 low, or in coded mode. It stays set until the mode register is written.
- R11: After each byte, the block waits exactly as many extra clock cycles as the delay in the byte's profile before the next byte starts. A delay of 0 adds no cycles.
- R12: SCK idles low and each of its levels lasts HALF clock cycles. MOSI presents the bits most significant first and changes only while SCK is low. MISO is sampled on each rising SCK edge.
- R13: When the target changes, all select lines are high for at least HALF clock cycles before the new line goes low. A line never changes directly into another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 mode, 1 data, 4–7 profiles |
| wr_data | input | 16 | Register write value |
| tx_empty | output | 1 | Data register free for the next byte |
| mode_fault | output | 1 | Sticky line-0 contention flag |
| rx_data | output | 8 | Last byte received |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Select outputs, active low or coded |
| cs0_sense_n | input | 1 | Sensed level of select line 0 |

## Verification
The hardest case to reach is the boundary between two bytes. The second byte must land in the data register after the first has been copied into the shifter but before its last SCK edge. The bench therefore waits for `tx_empty` to rise and writes the follow-up byte at once. It then counts the release edges on `cs_n` and measures the spacing of the `rx_valid` pulses, with the idle delay first at zero and then at twenty cycles. The fault masking case holds line 0 low through the hold bit and pulls the sense input low from outside.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int NCS = 4;
  localparam int FIELD_W = 4;
  localparam int IDX_W = 2;
  localparam int ADDR_W = 3;
  localparam int REG_W = 16;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG0 = 3'd4;

  localparam logic [FIELD_W-1:0] CS_IDLE = 4'hF;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_WAIT
  } seq_state_t;
endpackage

// File: rtl/spim_cs_map.sv
module spim_cs_map
  import spim_pkg::*;
(
  input  logic [FIELD_W-1:0] field_i,
  input  logic               coded_i,
  output logic [FIELD_W-1:0] pat_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               ok_o
);
  logic [IDX_W-1:0] low_idx;
  logic             any_zero;

  always_comb begin
    low_idx  = '0;
    any_zero = 1'b0;
    for (int i = NCS - 1; i >= 0; i--) begin
      if (!field_i[i]) begin
        low_idx  = IDX_W'(i);
        any_zero = 1'b1;
      end
    end
  end

  always_comb begin
    if (coded_i) begin
      pat_o = field_i;
      idx_o = field_i[FIELD_W-1 -: IDX_W];
      ok_o  = (field_i != CS_IDLE);
    end else begin
      pat_o = ~(FIELD_W'(1) << low_idx);
      idx_o = low_idx;
      ok_o  = any_zero;
    end
  end

  always_comb begin
    if (!coded_i && ok_o) begin
      assert_single_line_R1: assert ($countones(~pat_o) == 1 && !field_i[idx_o]);
    end
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int W    = 8,
  parameter int HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] tx_i,
  input  logic         miso_i,
  output logic         sck_o,
  output logic         mosi_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] rx_o
);
  localparam int PRE_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int PH_W  = $clog2(2 * W);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(HALF - 1);
  localparam logic [PH_W-1:0]  PH_TOP  = PH_W'(2 * W - 1);

  logic             act_q, act_d;
  logic             sck_q, sck_d;
  logic             done_q, done_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [W-1:0]     tx_q, tx_d;
  logic [W-1:0]     rx_q, rx_d;

  always_comb begin
    act_d  = act_q;
    sck_d  = sck_q;
    done_d = 1'b0;
    pre_d  = pre_q;
    ph_d   = ph_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (start_i) begin
      act_d = 1'b1;
      sck_d = 1'b0;
      pre_d = '0;
      ph_d  = '0;
      tx_d  = tx_i;
    end else if (act_q) begin
      if (pre_q == PRE_TOP) begin
        pre_d = '0;
        ph_d  = ph_q + 1'b1;
        if (!ph_q[0]) begin
          sck_d = 1'b1;
          rx_d  = {rx_q[W-2:0], miso_i};
        end else begin
          sck_d = 1'b0;
          tx_d  = {tx_q[W-2:0], 1'b0};
          if (ph_q == PH_TOP) begin
            act_d  = 1'b0;
            done_d = 1'b1;
          end
        end
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      pre_q  <= '0;
      ph_q   <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      act_q  <= act_d;
      sck_q  <= sck_d;
      done_q <= done_d;
      pre_q  <= pre_d;
      ph_q   <= ph_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = tx_q[W-1];
  assign busy_o = act_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

  assert_sck_idle_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !sck_q);
  assert_mosi_stable_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(mosi_o));
endmodule

// File: rtl/spim_cs_seq.sv
module spim_cs_seq
  import spim_pkg::*;
#(
  parameter int HALF   = 2,
  parameter int DLY_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [15:0]        wr_data,
  output logic               tx_empty,
  output logic               mode_fault,
  output logic [DATA_W-1:0]  rx_data,
  output logic               rx_valid,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic [3:0]         cs_n,
  input  logic               cs0_sense_n
);
  localparam int CNT_W = DLY_W + 1;
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(HALF);
  localparam int DLY_LSB = REG_W - DLY_W;

  // host register writes
  logic mode_we, data_we;
  logic [NCS-1:0] cfg_we;
  logic unused_wr;

  assign mode_we   = wr_en && (wr_addr == ADDR_MODE);
  assign data_we   = wr_en && (wr_addr == ADDR_DATA);
  assign unused_wr = ^wr_data;

  logic mode_coded_q, mode_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_coded_q <= 1'b0;
      mode_last_q  <= 1'b0;
    end else if (mode_we) begin
      mode_coded_q <= wr_data[0];
      mode_last_q  <= wr_data[1];
    end
  end

  logic             keep_q [NCS];
  logic [DLY_W-1:0] dly_q  [NCS];

  for (genvar g = 0; g < NCS; g++) begin : g_cfg
    assign cfg_we[g] = wr_en && (wr_addr == ADDR_W'(int'(ADDR_CFG0) + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        keep_q[g] <= 1'b0;
        dly_q[g]  <= '0;
      end else if (cfg_we[g]) begin
        keep_q[g] <= wr_data[0];
        dly_q[g]  <= wr_data[DLY_LSB +: DLY_W];
      end
    end
  end

  // pending byte
  logic              tdr_full_q, tdr_full_d;
  logic [DATA_W-1:0] tdr_data_q;
  logic [FIELD_W-1:0] tdr_field_q;
  logic              tdr_coded_q, tdr_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdr_data_q  <= '0;
      tdr_field_q <= CS_IDLE;
      tdr_coded_q <= 1'b0;
      tdr_last_q  <= 1'b0;
    end else if (data_we) begin
      tdr_data_q  <= wr_data[DATA_W-1:0];
      tdr_field_q <= wr_data[DATA_W +: FIELD_W];
      tdr_coded_q <= mode_coded_q;
      tdr_last_q  <= mode_last_q;
    end
  end

  logic [FIELD_W-1:0] map_pat;
  logic [IDX_W-1:0]   map_idx;
  logic               map_ok;

  spim_cs_map u_map (
    .field_i (tdr_field_q),
    .coded_i (tdr_coded_q),
    .pat_o   (map_pat),
    .idx_o   (map_idx),
    .ok_o    (map_ok)
  );

  // shifter
  logic sh_start, sh_busy, sh_done;

  spim_shifter #(.W(DATA_W), .HALF(HALF)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (sh_start),
    .tx_i    (tdr_data_q),
    .miso_i  (miso),
    .sck_o   (sck),
    .mosi_o  (mosi),
    .busy_o  (sh_busy),
    .done_o  (sh_done),
    .rx_o    (rx_data)
  );

  // sequencer
  seq_state_t         st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               cs_on_q, cs_on_d;
  logic [FIELD_W-1:0] cs_pat_q, cs_pat_d;
  logic [IDX_W-1:0]   cur_idx_q, cur_idx_d;
  logic               cur_last_q, cur_last_d;
  logic               same_tgt, release_now;
  logic [CNT_W-1:0]   gap_len;

  assign same_tgt    = tdr_full_q && map_ok && (map_pat == cs_pat_q);
  assign release_now = cur_last_q || (!keep_q[cur_idx_q] && !same_tgt);
  assign gap_len     = CNT_W'(dly_q[cur_idx_q]) + (release_now ? HALF_CNT : '0);

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    cs_on_d    = cs_on_q;
    cs_pat_d   = cs_pat_q;
    cur_idx_d  = cur_idx_q;
    cur_last_d = cur_last_q;
    tdr_full_d = tdr_full_q;
    sh_start   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (tdr_full_q) begin
          if (!map_ok) begin
            tdr_full_d = 1'b0;
          end else if (cs_on_q && map_pat == cs_pat_q) begin
            sh_start   = 1'b1;
            tdr_full_d = 1'b0;
            cur_last_d = tdr_last_q;
            cur_idx_d  = map_idx;
            st_d       = ST_SHIFT;
          end else if (cs_on_q) begin
            cs_on_d = 1'b0;
            cnt_d   = HALF_CNT;
            st_d    = ST_WAIT;
          end else begin
            cs_on_d   = 1'b1;
            cs_pat_d  = map_pat;
            cur_idx_d = map_idx;
            cnt_d     = HALF_CNT;
            st_d      = ST_LEAD;
          end
        end
      end
      ST_LEAD: begin
        if (cnt_q <= CNT_W'(1)) begin
          sh_start   = 1'b1;
          tdr_full_d = 1'b0;
          cur_last_d = tdr_last_q;
          st_d       = ST_SHIFT;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_SHIFT: begin
        if (sh_done) begin
          if (release_now) cs_on_d = 1'b0;
          if (gap_len == '0) begin
            st_d = ST_IDLE;
          end else begin
            cnt_d = gap_len;
            st_d  = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (cnt_q <= CNT_W'(1)) st_d = ST_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (data_we) tdr_full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      cs_on_q    <= 1'b0;
      cs_pat_q   <= CS_IDLE;
      cur_idx_q  <= '0;
      cur_last_q <= 1'b0;
      tdr_full_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      cs_on_q    <= cs_on_d;
      cs_pat_q   <= cs_pat_d;
      cur_idx_q  <= cur_idx_d;
      cur_last_q <= cur_last_d;
      tdr_full_q <= tdr_full_d;
    end
  end

  assign cs_n     = cs_on_q ? cs_pat_q : CS_IDLE;
  assign tx_empty = !tdr_full_q;
  assign rx_valid = sh_done;

  // line-0 contention flag
  logic mf_q, mf_set;

  assign mf_set = !mode_coded_q && cs_n[0] && !cs0_sense_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mf_q <= 1'b0;
    else if (mode_we) mf_q <= 1'b0;
    else if (mf_set) mf_q <= 1'b1;
  end

  assign mode_fault = mf_q;

  assert_cs_live_in_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> cs_n != CS_IDLE);
  assert_invalid_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && tdr_full_q && !map_ok && !data_we) |=> (tx_empty && !sh_busy));
  assert_empty_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_start && !data_we) |=> (tx_empty && sh_busy && !sck));
  assert_hold_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_done && same_tgt && !cur_last_q) |=> cs_n == $past(cs_n));
  assert_last_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_done && cur_last_q) |=> cs_n == CS_IDLE);
  assert_mf_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n[0] && !mode_we) |=> $stable(mode_fault));
  assert_no_direct_switch_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != CS_IDLE && $past(cs_n) != CS_IDLE) |-> cs_n == $past(cs_n));
endmodule

// File: tb/spim_cs_seq_tb.sv
module spim_cs_seq_tb;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        tx_empty, mode_fault, rx_valid, sck, mosi;
  logic [7:0]  rx_data;
  logic [3:0]  cs_n;
  logic        ext_n;
  logic        miso, cs0_sense_n;

  always #2 clk = ~clk;

  assign miso        = ~mosi;
  assign cs0_sense_n = cs_n[0] & ext_n;

  spim_cs_seq #(.HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_empty(tx_empty), .mode_fault(mode_fault), .rx_data(rx_data), .rx_valid(rx_valid),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .cs0_sense_n(cs0_sense_n)
  );

  int checks = 0, fails = 0, rx_cnt = 0, rel_cnt = 0;
  longint cyc = 0, stamp_last = 0, stamp_prev = 0;
  bit ended = 0;
  logic [11:0] exp_q[$];
  logic [7:0]  rxe_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // monitor: serial bytes, rx results, select-line timing
  logic       prev_sck = 1'b0;
  logic [3:0] prev_cs = 4'hF;
  logic [7:0] mon_sh;
  logic [3:0] mon_cs;
  int         mon_bits = 0, f_run = 0;
  bit         seen_active = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sck && !prev_sck) begin
        mon_sh = {mon_sh[6:0], mosi};
        mon_cs = cs_n;
        mon_bits++;
        if (mon_bits == 8) begin
          mon_bits = 0;
          if (exp_q.size() == 0) check(0, "R12 unexpected byte", {24'h0, mon_sh}, 0);
          else begin
            logic [11:0] e;
            e = exp_q.pop_front();
            check(mon_sh == e[7:0], "R12 mosi byte msb first", {24'h0, mon_sh}, {24'h0, e[7:0]});
            check(mon_cs == e[11:8], "R1 R2 select pattern", {28'h0, mon_cs}, {28'h0, e[11:8]});
          end
        end
      end
      if (rx_valid) begin
        rx_cnt++;
        stamp_prev = stamp_last;
        stamp_last = cyc;
        if (rxe_q.size() == 0) check(0, "R12 unexpected rx", {24'h0, rx_data}, 0);
        else begin
          logic [7:0] r;
          r = rxe_q.pop_front();
          check(rx_data == r, "R12 miso sampled", {24'h0, rx_data}, {24'h0, r});
        end
      end
      if (prev_cs != 4'hF && cs_n != 4'hF && cs_n != prev_cs)
        check(0, "R13 direct switch", {28'h0, cs_n}, {28'h0, prev_cs});
      if (prev_cs != 4'hF && cs_n == 4'hF) rel_cnt++;
      if (cs_n == 4'hF) f_run++;
      else begin
        if (prev_cs == 4'hF && seen_active)
          check(f_run >= HALF, "R13 release gap", f_run, HALF);
        f_run = 0;
        seen_active = 1;
      end
      prev_cs  = cs_n;
      prev_sck = sck;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input logic [3:0] f, input logic [7:0] d, input logic [3:0] pat);
    exp_q.push_back({pat, d});
    rxe_q.push_back(~d);
    wr(3'd1, {4'h0, f, d});
  endtask

  task automatic wait_rx(input int n, input string req);
    int t = 0;
    while (rx_cnt < n && t < 3000) begin @(negedge clk); t++; end
    check(rx_cnt >= n, req, rx_cnt, n);
    @(negedge clk);
  endtask

  task automatic wait_empty();
    int t = 0;
    while (!tx_empty && t < 200) begin @(negedge clk); t++; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // burst of two bytes to plain line 1, returns rx spacing
  task automatic pair_gap(output longint gap);
    int base = rx_cnt;
    send(4'b1101, 8'h81, 4'b1101);
    wait_empty();
    send(4'b1101, 8'h7E, 4'b1101);
    wait_rx(base + 2, "R7 burst done");
    gap = stamp_last - stamp_prev;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    finish_run();
  end

  initial begin
    longint g0, g1;
    int base, rel0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ext_n = 1'b1;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    check(cs_n == 4'hF, "R3 reset idle code", cs_n, 4'hF);
    check(tx_empty == 1'b1, "R6 reset empty", tx_empty, 1);
    check(sck == 1'b0, "R12 reset sck low", sck, 0);
    check(mode_fault == 1'b0, "R10 reset flag", mode_fault, 0);

    // R1 priority in plain mode
    wr(3'd0, 16'h0000);
    send(4'b1010, 8'hA5, 4'b1110);
    wait_rx(1, "R1 byte one");
    check(cs_n == 4'hF, "R3 released after byte", cs_n, 4'hF);
    send(4'b0011, 8'h3C, 4'b1011);
    wait_rx(2, "R1 byte two");

    // R6 empty on load, R7 hold on pending same target
    idle(10);
    rel0 = rel_cnt;
    base = rx_cnt;
    send(4'b1101, 8'hC3, 4'b1101);
    wait_empty();
    check(cs_n == 4'b1101 && !sck && rx_cnt == base, "R6 empty at load", {cs_n, 3'b0, sck}, {4'b1101, 4'b0});
    send(4'b1101, 8'h96, 4'b1101);
    wait_rx(base + 2, "R7 two bytes");
    idle(6);
    check(rel_cnt - rel0 == 1, "R7 single release", rel_cnt - rel0, 1);

    // R11 idle delay
    idle(10);
    pair_gap(g0);
    idle(10);
    wr(3'd5, 16'd20 << 8);
    pair_gap(g1);
    check(g1 - g0 == 20, "R11 delay cycles", 32'(g1 - g0), 20);
    wr(3'd5, 16'h0000);
    idle(30);

    // R2, R5, R8 coded mode with profile groups
    wr(3'd0, 16'h0001);
    wr(3'd5, 16'h0001);
    base = rx_cnt;
    send(4'h6, 8'h5A, 4'h6);
    wait_rx(base + 1, "R2 coded byte");
    idle(12);
    check(cs_n == 4'h6, "R8 held by profile 1", cs_n, 4'h6);
    send(4'h5, 8'h12, 4'h5);
    wait_rx(base + 2, "R13 switch byte");
    idle(12);
    check(cs_n == 4'h5, "R5 code 5 uses profile 1", cs_n, 4'h5);
    send(4'h2, 8'hE7, 4'h2);
    wait_rx(base + 3, "R5 code 2 byte");
    idle(6);
    check(cs_n == 4'hF, "R5 code 2 uses profile 0", cs_n, 4'hF);

    // R9 end-of-burst beats hold
    wr(3'd0, 16'h0003);
    send(4'h7, 8'h0F, 4'h7);
    wait_rx(base + 4, "R9 last byte");
    idle(2);
    check(cs_n == 4'hF, "R9 released", cs_n, 4'hF);
    wr(3'd0, 16'h0001);

    // R4 dropped codes
    base = rx_cnt;
    wr(3'd1, 16'h0F11);
    idle(40);
    check(tx_empty && rx_cnt == base && cs_n == 4'hF && exp_q.size() == 0, "R4 coded F dropped",
          {tx_empty, 3'b0, cs_n, 24'(rx_cnt - base)}, {1'b1, 3'b0, 4'hF, 24'h0});
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0F22);
    idle(40);
    check(tx_empty && rx_cnt == base && cs_n == 4'hF, "R4 plain none dropped",
          {tx_empty, 3'b0, cs_n}, {1'b1, 3'b0, 4'hF});

    // R10 fault flag
    ext_n = 1'b0;
    idle(3);
    check(mode_fault == 1'b1, "R10 fault raised", mode_fault, 1);
    ext_n = 1'b1;
    wr(3'd0, 16'h0000);
    idle(2);
    check(mode_fault == 1'b0, "R10 fault cleared", mode_fault, 0);
    wr(3'd4, 16'h0001);
    send(4'b1110, 8'h66, 4'b1110);
    wait_rx(base + 1, "R10 line 0 byte");
    idle(4);
    check(cs_n == 4'b1110, "R8 line 0 held", cs_n, 4'b1110);
    ext_n = 1'b0;
    idle(10);
    check(mode_fault == 1'b0, "R10 masked while held", mode_fault, 0);
    ext_n = 1'b1;
    wr(3'd0, 16'h0002);
    send(4'b1110, 8'h99, 4'b1110);
    wait_rx(base + 2, "R9 line 0 last");
    idle(6);
    check(cs_n == 4'hF, "R9 line 0 released", cs_n, 4'hF);
    wr(3'd0, 16'h0001);
    ext_n = 1'b0;
    idle(10);
    check(mode_fault == 1'b0, "R10 ignored when coded", mode_fault, 0);
    ext_n = 1'b1;

    idle(10);
    check(exp_q.size() == 0 && rxe_q.size() == 0, "R12 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule